// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block is the host-side engine that writes one byte into a parallel UV-erasable memory. It uses repeated program pulses, each followed by a read-back. When the host raises a start request it gives a 15-bit location and an 8-bit value. The block first reads the present contents with the program supply off. It refuses the request if the value would need any cell turned from 0 back to 1, because only erased cells read as 1.

If the request is accepted, the block switches the program supply on and drives the address and the data. It then lowers chip enable for a fixed number of clock cycles. Next it releases the data bus and reads the byte back with chip enable high and output enable low. It stops at the first read-back that matches. It gives up after the pulse limit. At the end it reports one of three results (done, fail or reject) together with the number of pulses it used.

The pulse width, the read settle time and the setup time are all counted in clock cycles, set by parameters. The defaults suit a 200 MHz clock: a pulse of 100 µs and a settle time of 100 ns.

Top module: `eprom_pulse_prog`

## Requirements
- R1: After reset, and whenever the block is idle, chip enable and output enable are high (inactive), the program supply enable and the data-bus driver enable are low, and busy, done, fail and reject are low. The pulse count is 0 after reset.
- R2: After a start, the block first holds chip enable low and output enable low with the program supply off for SETTLE_CYC cycles, then samples the data bus. If the requested byte has a 1 in any bit position where the sampled byte has a 0, the block pulses reject and issues no program pulse. The pulse count then stays 0 and the memory keeps its contents.
- R3: Each program pulse holds chip enable low for exactly PULSE_CYC cycles. During the pulse, output enable is high, the program supply is on, and the address and data outputs are driven and stable. The data driver is on for at least SETUP_CYC cycles with chip enable high before chip enable falls.
- R4: After each pulse, the block reads back with chip enable high, output enable low and the program supply on, for exactly SETTLE_CYC cycles, and samples the data bus in the last of those cycles.
- R5: The data-bus driver is never enabled while output enable is low. It is off for at least one full cycle before output enable falls.
- R6: The first read-back that equals the requested byte ends the operation with a done pulse. No further program pulse follows it.
- R7: If the read-back still differs after pulse MAX_PULSES (10 by default), the operation ends with a fail pulse. The pulse count never exceeds MAX_PULSES.
- R8: Done, fail and reject are single-cycle pulses, and at most one of them is high at a time. The pulse count (1 to 10 for done or fail) is valid in the result cycle and holds until the next accepted start, which clears it to 0.
- R9: A start request while busy is ignored. The address output, the ongoing operation and its result are unaffected, and no second operation follows.
- R10: A match on the last allowed read-back gives done, not fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| addr_i | input | ADDR_W | Byte location to program |
| data_i | input | DATA_W | Byte value to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Single-cycle pulse: byte verified |
| fail_o | output | 1 | Single-cycle pulse: pulse limit reached without match |
| reject_o | output | 1 | Single-cycle pulse: request needs a 0-to-1 change |
| pulses_o | output | CNT_W | Program pulses used by the last operation |
| mem_addr_o | output | ADDR_W | Address bus to the memory |
| mem_dq_o | output | DATA_W | Data bus value driven to the memory |
| mem_dq_oe_o | output | 1 | Data-bus driver enable |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_vpp_en_o | output | 1 | Program supply enable |
| mem_dq_i | input | DATA_W | Data bus value read from the memory |

## Verification
Two things can land in the same cycle. A result pulse marks the end of one operation, and a fresh start request can be accepted in that same cycle. The bench raises start in the very cycle it sees done. It then checks that done lasts one cycle, that the old count is visible in that cycle and cleared on the next, and that the second operation runs to its own correct count. The other coincidence is a verify match on the tenth pulse, where the match and the limit fall together. A memory model that needs exactly ten pulses triggers this case, and the bench expects done with a count of 10.

// File: rtl/eprom_pp_pkg.sv
package eprom_pp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PREREAD = 3'd1,
        ST_GAP_W   = 3'd2,
        ST_SETUP   = 3'd3,
        ST_PULSE   = 3'd4,
        ST_GAP_R   = 3'd5,
        ST_VERIFY  = 3'd6
    } pp_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Pin levels as a function of the state being entered
    function automatic logic ce_active(input pp_state_e s);
        return (s == ST_PREREAD) || (s == ST_PULSE);
    endfunction

    function automatic logic oe_active(input pp_state_e s);
        return (s == ST_PREREAD) || (s == ST_VERIFY);
    endfunction

    function automatic logic supply_on(input pp_state_e s);
        return (s == ST_GAP_W) || (s == ST_SETUP) || (s == ST_PULSE) ||
               (s == ST_GAP_R) || (s == ST_VERIFY);
    endfunction

    function automatic logic bus_driven(input pp_state_e s);
        return (s == ST_SETUP) || (s == ST_PULSE);
    endfunction

endpackage

// File: rtl/eprom_pp_timer.sv
module eprom_pp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/eprom_pp_judge.sv
module eprom_pp_judge #(
    parameter int W = 8
) (
    input  logic [W-1:0] want_i,
    input  logic [W-1:0] got_i,
    output logic         conflict_o,
    output logic         match_o
);
    // A wanted 1 over a stored 0 cannot be reached by programming
    assign conflict_o = |(want_i & ~got_i);
    assign match_o    = (want_i == got_i);

endmodule

// File: rtl/eprom_pulse_prog.sv
module eprom_pulse_prog
    import eprom_pp_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 20000,
    parameter int SETTLE_CYC = 20,
    parameter int SETUP_CYC  = 2,
    parameter int MAX_PULSES = 10,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              reject_o,
    output logic [CNT_W-1:0]  pulses_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_vpp_en_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int TMAX = max3(PULSE_CYC, SETTLE_CYC, SETUP_CYC);
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        pp_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              fail;
        logic              reject;
        logic              ce_n;
        logic              oe_n;
        logic              vpp;
        logic              dq_oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;
    logic          conflict;
    logic          match;

    eprom_pp_timer #(.W(TW)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    eprom_pp_judge #(.W(DATA_W)) judge_i (
        .want_i     (ctl_q.data),
        .got_i      (mem_dq_i),
        .conflict_o (conflict),
        .match_o    (match)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        ctl_d.fail   = 1'b0;
        ctl_d.reject = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.addr = addr_i;
                    ctl_d.data = data_i;
                    ctl_d.cnt  = '0;
                    ctl_d.st   = ST_PREREAD;
                end
            end
            ST_PREREAD: begin
                if (tmr_last) begin
                    if (conflict) begin
                        ctl_d.reject = 1'b1;
                        ctl_d.st     = ST_IDLE;
                    end else begin
                        ctl_d.st     = ST_GAP_W;
                    end
                end
            end
            ST_GAP_W: begin
                ctl_d.st = ST_SETUP;
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    ctl_d.st  = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_last) begin
                    ctl_d.st = ST_GAP_R;
                end
            end
            ST_GAP_R: begin
                ctl_d.st = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (tmr_last) begin
                    if (match) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = ST_IDLE;
                    end else if (ctl_q.cnt >= CNT_W'(MAX_PULSES)) begin
                        ctl_d.fail = 1'b1;
                        ctl_d.st   = ST_IDLE;
                    end else begin
                        ctl_d.st   = ST_GAP_W;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase

        // Pin levels are registered together with the state they belong to
        ctl_d.ce_n  = !ce_active(ctl_d.st);
        ctl_d.oe_n  = !oe_active(ctl_d.st);
        ctl_d.vpp   = supply_on(ctl_d.st);
        ctl_d.dq_oe = bus_driven(ctl_d.st);

        tmr_load = (ctl_d.st != ctl_q.st);
        unique case (ctl_d.st)
            ST_PREREAD, ST_VERIFY: tmr_val = TW'(SETTLE_CYC - 1);
            ST_SETUP:              tmr_val = TW'(SETUP_CYC - 1);
            ST_PULSE:              tmr_val = TW'(PULSE_CYC - 1);
            default:               tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= ST_IDLE;
            ctl_q.ce_n   <= 1'b1;
            ctl_q.oe_n   <= 1'b1;
        end else begin
            ctl_q        <= ctl_d;
        end
    end

    assign busy_o       = (ctl_q.st != ST_IDLE);
    assign done_o       = ctl_q.done;
    assign fail_o       = ctl_q.fail;
    assign reject_o     = ctl_q.reject;
    assign pulses_o     = ctl_q.cnt;
    assign mem_addr_o   = ctl_q.addr;
    assign mem_dq_o     = ctl_q.data;
    assign mem_dq_oe_o  = ctl_q.dq_oe;
    assign mem_ce_n_o   = ctl_q.ce_n;
    assign mem_oe_n_o   = ctl_q.oe_n;
    assign mem_vpp_en_o = ctl_q.vpp;

endmodule

// File: rtl/eprom_pp_chk.sv
module eprom_pp_chk #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 20000,
    parameter int MAX_PULSES = 10,
    parameter int CNT_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              reject_o,
    input logic [CNT_W-1:0]  pulses_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_vpp_en_o
);
    localparam int PW = $clog2(PULSE_CYC + 2);

    logic [PW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!mem_ce_n_o && mem_vpp_en_o) begin
            low_run <= low_run + PW'(1);
        end else begin
            low_run <= '0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_ce_n_o && mem_oe_n_o && !mem_vpp_en_o && !mem_dq_oe_o));

    // R2
    reject_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> (pulses_o == '0));

    // R3
    pulse_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && mem_vpp_en_o) |-> (mem_oe_n_o && mem_dq_oe_o));

    // R3
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n_o) && $past(mem_vpp_en_o)) |-> (low_run == PW'(PULSE_CYC)));

    // R4
    verify_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n_o && mem_vpp_en_o) |-> (mem_ce_n_o && !mem_dq_oe_o));

    // R5
    bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe_o && !mem_oe_n_o));

    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));

    // R7
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_o <= CNT_W'(MAX_PULSES));

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o, reject_o}));

    // R8
    result_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || reject_o) |=> !(done_o || fail_o || reject_o));

endmodule

bind eprom_pulse_prog eprom_pp_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .MAX_PULSES (MAX_PULSES),
    .CNT_W      (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .reject_o     (reject_o),
    .pulses_o     (pulses_o),
    .mem_addr_o   (mem_addr_o),
    .mem_dq_o     (mem_dq_o),
    .mem_dq_oe_o  (mem_dq_oe_o),
    .mem_ce_n_o   (mem_ce_n_o),
    .mem_oe_n_o   (mem_oe_n_o),
    .mem_vpp_en_o (mem_vpp_en_o)
);

// File: tb/eprom_pulse_prog_tb_top.sv
`timescale 1ns/1ps
module eprom_pulse_prog_tb_top;

    localparam int PULSE  = 6;
    localparam int SETTLE = 3;
    localparam int SETUP  = 2;
    localparam int MAXP   = 10;
    localparam int NVEC   = 7;

    // {addr[15], init[8], need[4], data[8], kind[2], count[4]}; kind 0 done, 1 fail, 2 reject
    localparam logic [40:0] VECS [0:NVEC-1] = '{
        {15'h0100, 8'hFF, 4'd1,  8'hA5, 2'd0, 4'd1},
        {15'h2341, 8'hFF, 4'd3,  8'h00, 2'd0, 4'd3},
        {15'h7FF2, 8'hFF, 4'd10, 8'h3C, 2'd0, 4'd10},
        {15'h0003, 8'hFF, 4'd11, 8'h12, 2'd1, 4'd10},
        {15'h1234, 8'hF0, 4'd1,  8'hF1, 2'd2, 4'd0},
        {15'h4445, 8'h0F, 4'd2,  8'h0E, 2'd0, 4'd2},
        {15'h5556, 8'hA5, 4'd1,  8'hA5, 2'd0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done, fail, reject;
    logic [3:0]  pulses;
    logic [14:0] m_addr;
    logic [7:0]  m_dq_o;
    logic        m_dq_oe, m_ce_n, m_oe_n, m_vpp;
    logic [7:0]  dq_in = 8'h00;

    always #2.5 clk = ~clk;

    eprom_pulse_prog #(
        .PULSE_CYC  (PULSE),
        .SETTLE_CYC (SETTLE),
        .SETUP_CYC  (SETUP),
        .MAX_PULSES (MAXP)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .addr_i       (addr),
        .data_i       (wdata),
        .busy_o       (busy),
        .done_o       (done),
        .fail_o       (fail),
        .reject_o     (reject),
        .pulses_o     (pulses),
        .mem_addr_o   (m_addr),
        .mem_dq_o     (m_dq_o),
        .mem_dq_oe_o  (m_dq_oe),
        .mem_ce_n_o   (m_ce_n),
        .mem_oe_n_o   (m_oe_n),
        .mem_vpp_en_o (m_vpp),
        .mem_dq_i     (dq_in)
    );

    // ---------------- memory model and pin monitor ----------------
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [7:0]  ld_val = '0;
    int          ld_need = 0;

    logic [7:0]  mem [16];
    int          need [16];
    int          hits [16];
    int          pulses_seen = 0;
    int          low_run = 0, drv_run = 0, rd_run = 0;
    int          e_width = 0, e_setup = 0, e_hold = 0, e_settle = 0, e_clash = 0;
    logic        p_ce_n = 1'b1, p_oe_n = 1'b1, p_vpp = 1'b0, p_dq_oe = 1'b0;
    logic [7:0]  p_dq = '0;
    logic [14:0] p_addr = '0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]  = 8'hFF;
            need[i] = 1;
            hits[i] = 0;
        end
    end

    always @(negedge clk) begin : model
        logic [3:0] idx;
        logic       read_ok;
        idx = m_addr[3:0];
        if (ld_en) begin
            mem[ld_idx]  = ld_val;
            need[ld_idx] = ld_need;
            hits[ld_idx] = 0;
            pulses_seen  = 0;
        end
        if (rst_n) begin
            if (m_dq_oe && !m_oe_n) e_clash++;
            if (p_oe_n && !m_oe_n && p_dq_oe) e_clash++;
            if (!m_ce_n && m_vpp) begin
                if (!p_ce_n && (m_addr != p_addr || m_dq_o != p_dq)) e_hold++;
                if (p_ce_n && drv_run < SETUP) e_setup++;
                low_run++;
            end else if (!p_ce_n && p_vpp) begin
                if (low_run != PULSE) e_width++;
                low_run = 0;
                pulses_seen++;
                hits[idx]++;
                if (hits[idx] >= need[idx]) mem[idx] = mem[idx] & p_dq;
            end
            drv_run = (m_dq_oe && m_ce_n) ? drv_run + 1 : 0;
            read_ok = !m_oe_n && !m_dq_oe && ((m_vpp && m_ce_n) || (!m_vpp && !m_ce_n));
            if (read_ok) begin
                rd_run++;
            end else begin
                if (rd_run != 0 && rd_run != SETTLE) e_settle++;
                rd_run = 0;
            end
            dq_in = (read_ok && rd_run >= SETTLE) ? mem[idx] : ~mem[idx];
        end
        p_ce_n  = m_ce_n;
        p_oe_n  = m_oe_n;
        p_vpp   = m_vpp;
        p_dq_oe = m_dq_oe;
        p_dq    = m_dq_o;
        p_addr  = m_addr;
    end

    // ---------------- checking helpers ----------------
    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [3:0] idx, input logic [7:0] val, input int nd);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_idx = idx; ld_val = val; ld_need = nd;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic launch(input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_result(output logic [2:0] res, output logic [3:0] cnt);
        res = 3'b000;
        cnt = '0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk); #1;
            if (done || fail || reject) begin
                res = {done, fail, reject};
                cnt = pulses;
                break;
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [2:0] res;
        logic [3:0] cnt;
        logic [2:0] exp_res;
        repeat (3) @(negedge clk);
        #1;
        // R1: levels while reset is held
        chk("R1 reset pins", {m_ce_n, m_oe_n, m_vpp, m_dq_oe}, 4'b1100);
        chk("R1 reset status", {busy, done, fail, reject, pulses}, 8'h00);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 idle after reset", {busy, m_ce_n, m_oe_n, m_vpp, m_dq_oe, pulses}, {5'b01100, 4'h0});

        // Table walk: R2 R6 R7 R10 results, counts, pulses seen, memory contents
        for (int v = 0; v < NVEC; v++) begin
            logic [14:0] a;
            logic [7:0]  ini, d;
            logic [3:0]  nd, ec;
            logic [1:0]  kind;
            {a, ini, nd, d, kind, ec} = VECS[v];
            preload(a[3:0], ini, int'(nd));
            launch(a, d);
            wait_result(res, cnt);
            exp_res = (kind == 2'd0) ? 3'b100 : (kind == 2'd1) ? 3'b010 : 3'b001;
            chk($sformatf("R6 R7 R2 result vec%0d", v), res, exp_res);
            chk($sformatf("R8 count vec%0d", v), cnt, ec);
            chk($sformatf("R6 pulses issued vec%0d", v), pulses_seen, ec);
            chk($sformatf("R2 memory contents vec%0d", v), mem[a[3:0]], (kind == 2'd0) ? d : ini);
            @(negedge clk); #1;
            chk($sformatf("R8 single pulse and held count vec%0d", v),
                {done, fail, reject, busy, pulses}, {4'b0000, ec});
        end

        // R10: the ten-pulse match of vec2 already expected done; recheck the limit case count cap
        chk("R10 R7 count never above limit", (pulses <= 4'(MAXP)), 1'b1);

        // R9: start while busy is ignored
        preload(4'h7, 8'hFF, 2);
        preload(4'h8, 8'hFF, 1);
        launch(15'h0A07, 8'h55);
        repeat (3) @(posedge clk);
        #1;
        addr = 15'h7FF8; wdata = 8'h00; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk); #1;
        chk("R9 address kept while busy", m_addr, 15'h0A07);
        wait_result(res, cnt);
        chk("R9 first op result", res, 3'b100);
        chk("R9 first op count", cnt, 4'd2);
        repeat (4) @(negedge clk);
        #1;
        chk("R9 no second op", {busy, m_addr}, {1'b0, 15'h0A07});
        chk("R9 other location untouched", mem[8], 8'hFF);

        // R8: start accepted in the cycle of done
        preload(4'h9, 8'hFF, 1);
        preload(4'hA, 8'hFF, 2);
        launch(15'h0019, 8'h0F);
        wait_result(res, cnt);
        chk("R8 b2b first result", res, 3'b100);
        chk("R8 count valid in result cycle", cnt, 4'd1);
        addr = 15'h001A; wdata = 8'hF0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk); #1;
        chk("R8 b2b done single and count cleared", {done, busy, pulses}, {2'b01, 4'h0});
        wait_result(res, cnt);
        chk("R8 b2b second result", res, 3'b100);
        chk("R8 b2b second count", cnt, 4'd2);
        chk("R8 b2b second contents", mem[10], 8'hF0);

        // Pin-timing monitor summaries
        chk("R3 pulse width", e_width, 0);
        chk("R3 setup before pulse", e_setup, 0);
        chk("R3 address and data held", e_hold, 0);
        chk("R4 R2 read settle window", e_settle, 0);
        chk("R5 bus turnaround", e_clash, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule